// File: doc/BRIEF.md
# Packet Receive Sequencer

This block runs the whole receive flow for a variable-length packet. It issues its commands, one byte at a time, to an SPI register access master that sits beside it. A one-cycle `start` pulse carries a host limit on the payload length. The sequencer then sends the receive-on strobe and waits until the end-of-packet pin from the radio goes low. Next it reads the FIFO fill count and then the length prefix. When the length is within the limit, it streams the payload out one byte per strobe, collects the two trailing status bytes and flushes the FIFO.

The result is a single `done` pulse. With it come a pass flag, the received length, the signal-strength byte and a 7-bit link-quality value. The pass flag is set only when the packet was accepted and the CRC bit in the trailing status is set. If the end-of-packet wait runs too long, the sequence is aborted: the radio is sent to idle, the FIFO is flushed and the attempt reports failure.

Every command is one frame on the byte interface. A header byte is marked `xfer_first`. Zero or more data bytes follow, each sent as 0x00, and the final byte of the frame is marked `xfer_last`. `xfer_req` stays high, with the byte and its marks unchanged, until the master pulses `xfer_ack`. A byte read back is taken from `xfer_rx` in the cycle of that ack.

Top module: `prx_rx_sequencer`

## Requirements
- R1: While reset is held, and after it is released, `xfer_req`, `done` and `pay_valid` stay low until a start is accepted.
- R2: A `start` pulse is accepted only when the block is idle. Its first frame is the single-byte strobe 0x34. A start that arrives while a sequence runs, including in the cycle where `done` is high, has no effect.
- R3: After the strobe, no further frame is issued while `pkt_pin` is high. This input passes through a two-stage synchronizer. Once it reads low, the sequence continues.
- R4: The count read is a frame with header 0xFB and one data byte. If bits 6:0 of the returned byte are zero, the block finishes with failure, length 0, and issues no flush.
- R5: The length read is a frame with header 0xBF and one data byte. The returned byte is reported on `res_len`.
- R6: When the length is at most `max_len` (a length of zero counts), a frame with header 0xFF and exactly that many data bytes follows. Each returned byte appears in order on `pay_data`, with `pay_valid` high for one cycle. A second 0xFF frame with two data bytes then reads the status.
- R7: On the accepted path, `res_rssi` is the first status byte, `res_lqi` is bits 6:0 of the second, and `res_ok` is bit 7 of the second. `done` is a one-cycle pulse.
- R8: When the length exceeds `max_len`, no payload frame is issued, no payload byte is output, `res_len` still shows the length, and `res_ok` is 0.
- R9: The accepted path and the over-length path both end with the single-byte flush strobe 0x3A before `done`. No request is pending while `done` is high.
- R10: If `pkt_pin` stays high for TIMEOUT_CYC cycles of the wait, the block issues the strobe 0x36 and then 0x3A, and finishes with `res_ok` 0 and `res_len` 0.
- R11: Every frame opens with `xfer_first` on its header and closes with `xfer_last` on its final byte. Data bytes are sent as 0x00. A byte and its marks hold steady until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start one receive attempt |
| max_len | input | 8 | Largest payload length accepted |
| pkt_pin | input | 1 | End-of-packet pin, high while a packet is in progress |
| xfer_req | output | 1 | Byte transfer request to the SPI master |
| xfer_tx | output | 8 | Byte to send |
| xfer_first | output | 1 | Byte opens a frame (chip select asserted) |
| xfer_last | output | 1 | Byte closes a frame (chip select released) |
| xfer_ack | input | 1 | Current byte has been transferred |
| xfer_rx | input | 8 | Byte received, valid with `xfer_ack` |
| pay_valid | output | 1 | Payload byte strobe |
| pay_data | output | 8 | Payload byte |
| done | output | 1 | Attempt finished (one cycle) |
| res_ok | output | 1 | Packet accepted and CRC passed |
| res_len | output | 8 | Received length byte |
| res_rssi | output | 8 | Signal-strength status byte |
| res_lqi | output | 7 | Link-quality value |

## Verification
A new `start` can coincide with the completion pulse, because a host that loops on receive attempts tends to restart as soon as it sees `done`. The bench provokes this by raising `start` in the exact cycle where it observes `done` high. It then watches the byte interface for several dozen cycles and expects no new request and no change in the reported results. A second race, between the end-of-packet pin falling and the wait timer running out, is settled in favour of the pin. The bench checks the boundary by holding the pin high for somewhat less than the timeout and confirming that the normal read sequence follows.

// File: rtl/prx_pkg.sv
package prx_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // command codes and register addresses seen by the radio
    localparam byte_t OP_RX_ON   = 8'h34;
    localparam byte_t OP_IDLE    = 8'h36;
    localparam byte_t OP_FLUSH   = 8'h3A;
    localparam byte_t AD_NBYTES  = 8'h3B;
    localparam byte_t AD_FIFO    = 8'h3F;
    localparam byte_t FL_READ    = 8'h80;
    localparam byte_t FL_BURST   = 8'h40;
    localparam byte_t CNT_MASK   = 8'h7F;
    localparam byte_t ST_BYTES   = 8'd2;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_RXON, SQ_WAIT, SQ_CNT, SQ_LEN, SQ_PAY, SQ_STAT,
        SQ_FLUSH, SQ_ABT_IDLE, SQ_ABT_FLUSH, SQ_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {FX_IDLE, FX_HDR, FX_DATA} fx_state_e;

    typedef struct packed {
        logic  is_frame;
        byte_t hdr;
        byte_t cnt;
    } frame_cmd_t;

    typedef struct packed {
        logic        ok;
        byte_t       len;
        byte_t       rssi;
        logic [6:0]  lqi;
    } rx_result_t;

    function automatic byte_t read_hdr(byte_t addr, logic burst);
        return addr | FL_READ | (burst ? FL_BURST : 8'h00);
    endfunction

    // which frame a sequencer state issues, if any
    function automatic frame_cmd_t frame_of(seq_state_e s, byte_t plen);
        frame_cmd_t f;
        f = '{is_frame: 1'b1, hdr: 8'h00, cnt: 8'h00};
        case (s)
            SQ_RXON:      f.hdr = OP_RX_ON;
            SQ_CNT:       begin f.hdr = read_hdr(AD_NBYTES, 1'b1); f.cnt = 8'd1; end
            SQ_LEN:       begin f.hdr = read_hdr(AD_FIFO, 1'b0);   f.cnt = 8'd1; end
            SQ_PAY:       begin f.hdr = read_hdr(AD_FIFO, 1'b1);   f.cnt = plen; end
            SQ_STAT:      begin f.hdr = read_hdr(AD_FIFO, 1'b1);   f.cnt = ST_BYTES; end
            SQ_FLUSH,
            SQ_ABT_FLUSH: f.hdr = OP_FLUSH;
            SQ_ABT_IDLE:  f.hdr = OP_IDLE;
            default:      f.is_frame = 1'b0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/prx_frame_xfer.sv
module prx_frame_xfer
    import prx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  byte_t hdr,
    input  byte_t cnt,
    output logic  xfer_req,
    output byte_t xfer_tx,
    output logic  xfer_first,
    output logic  xfer_last,
    input  logic  xfer_ack,
    input  byte_t xfer_rx,
    output logic  rx_valid,
    output byte_t rx_data,
    output byte_t rx_idx,
    output logic  fdone
);

    fx_state_e st;
    byte_t     remain;
    byte_t     idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= FX_IDLE;
            xfer_req   <= 1'b0;
            xfer_tx    <= '0;
            xfer_first <= 1'b0;
            xfer_last  <= 1'b0;
            remain     <= '0;
            idx        <= '0;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            rx_idx     <= '0;
            fdone      <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            fdone    <= 1'b0;
            case (st)
                FX_IDLE: begin
                    if (go) begin
                        st         <= FX_HDR;
                        xfer_req   <= 1'b1;
                        xfer_tx    <= hdr;
                        xfer_first <= 1'b1;
                        xfer_last  <= (cnt == '0);
                        remain     <= cnt;
                    end
                end
                FX_HDR: begin
                    if (xfer_ack) begin
                        xfer_first <= 1'b0;
                        if (remain == '0) begin
                            st        <= FX_IDLE;
                            xfer_req  <= 1'b0;
                            xfer_last <= 1'b0;
                            fdone     <= 1'b1;
                        end else begin
                            st        <= FX_DATA;
                            xfer_tx   <= '0;
                            xfer_last <= (remain == 8'd1);
                            idx       <= '0;
                        end
                    end
                end
                FX_DATA: begin
                    if (xfer_ack) begin
                        rx_valid <= 1'b1;
                        rx_data  <= xfer_rx;
                        rx_idx   <= idx;
                        idx      <= idx + 8'd1;
                        remain   <= remain - 8'd1;
                        if (remain == 8'd1) begin
                            st        <= FX_IDLE;
                            xfer_req  <= 1'b0;
                            xfer_last <= 1'b0;
                            fdone     <= 1'b1;
                        end else begin
                            xfer_last <= (remain == 8'd2);
                        end
                    end
                end
                default: st <= FX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/prx_eop_watch.sv
module prx_eop_watch #(
    parameter int TIMEOUT_CYC = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic pin,
    output logic eop,
    output logic tmo
);

    localparam int CW = $clog2(TIMEOUT_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          hi_cnt;
    logic                   pin_s;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    assign pin_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst || !en)         hi_cnt <= '0;
        else if (pin_s && !tmo) hi_cnt <= hi_cnt + 1'b1;
    end

    // a low pin wins over an expiring counter
    assign eop = en && !pin_s;
    assign tmo = en && pin_s && (hi_cnt == CW'(TIMEOUT_CYC - 1));

endmodule

// File: rtl/prx_seq_ctrl.sv
module prx_seq_ctrl
    import prx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  byte_t      max_len,
    input  logic       eop,
    input  logic       tmo,
    input  logic       f_done,
    input  logic       f_rx_valid,
    input  byte_t      f_rx_data,
    input  byte_t      f_rx_idx,
    output logic       wait_en,
    output logic       f_go,
    output byte_t      f_hdr,
    output byte_t      f_cnt,
    output logic       pay_valid,
    output byte_t      pay_data,
    output logic       done,
    output rx_result_t result
);

    seq_state_e st, st_n;
    logic       launched;
    byte_t      max_q;
    frame_cmd_t fc;

    assign fc    = frame_of(st, result.len);
    assign f_go  = fc.is_frame && !launched;
    assign f_hdr = fc.hdr;
    assign f_cnt = fc.cnt;

    always_comb begin
        st_n = st;
        case (st)
            SQ_IDLE:      if (start) st_n = SQ_RXON;
            SQ_RXON:      if (f_done) st_n = SQ_WAIT;
            SQ_WAIT:      if (tmo) st_n = SQ_ABT_IDLE;
                          else if (eop) st_n = SQ_CNT;
            SQ_CNT:       if (f_done) st_n = ((f_rx_data & CNT_MASK) == '0) ? SQ_FINISH : SQ_LEN;
            SQ_LEN:       if (f_done) st_n = (f_rx_data <= max_q) ? SQ_PAY : SQ_FLUSH;
            SQ_PAY:       if (f_done) st_n = SQ_STAT;
            SQ_STAT:      if (f_done) st_n = SQ_FLUSH;
            SQ_FLUSH:     if (f_done) st_n = SQ_FINISH;
            SQ_ABT_IDLE:  if (f_done) st_n = SQ_ABT_FLUSH;
            SQ_ABT_FLUSH: if (f_done) st_n = SQ_FINISH;
            SQ_FINISH:    st_n = SQ_IDLE;
            default:      st_n = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            launched <= 1'b0;
            max_q    <= '0;
            result   <= '0;
        end else begin
            st       <= st_n;
            launched <= (st_n != st) ? 1'b0 : (launched | f_go);
            if (st == SQ_IDLE && start) begin
                max_q  <= max_len;
                result <= '0;
            end
            if (st == SQ_LEN && f_rx_valid) result.len <= f_rx_data;
            if (st == SQ_STAT && f_rx_valid) begin
                if (f_rx_idx == '0) begin
                    result.rssi <= f_rx_data;
                end else begin
                    result.lqi <= f_rx_data[6:0];
                    result.ok  <= f_rx_data[7];
                end
            end
        end
    end

    assign wait_en   = (st == SQ_WAIT);
    assign pay_valid = f_rx_valid && (st == SQ_PAY);
    assign pay_data  = f_rx_data;
    assign done      = (st == SQ_FINISH);

endmodule

// File: rtl/prx_rx_sequencer.sv
module prx_rx_sequencer
    import prx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] max_len,
    input  logic       pkt_pin,
    output logic       xfer_req,
    output logic [7:0] xfer_tx,
    output logic       xfer_first,
    output logic       xfer_last,
    input  logic       xfer_ack,
    input  logic [7:0] xfer_rx,
    output logic       pay_valid,
    output logic [7:0] pay_data,
    output logic       done,
    output logic       res_ok,
    output logic [7:0] res_len,
    output logic [7:0] res_rssi,
    output logic [6:0] res_lqi
);

    logic       wait_en, eop, tmo;
    logic       f_go, f_done, f_rx_valid;
    byte_t      f_hdr, f_cnt, f_rx_data, f_rx_idx;
    rx_result_t result;

    prx_eop_watch #(
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_eop (
        .clk (clk),
        .rst (rst),
        .en  (wait_en),
        .pin (pkt_pin),
        .eop (eop),
        .tmo (tmo)
    );

    prx_frame_xfer u_fx (
        .clk        (clk),
        .rst        (rst),
        .go         (f_go),
        .hdr        (f_hdr),
        .cnt        (f_cnt),
        .xfer_req   (xfer_req),
        .xfer_tx    (xfer_tx),
        .xfer_first (xfer_first),
        .xfer_last  (xfer_last),
        .xfer_ack   (xfer_ack),
        .xfer_rx    (xfer_rx),
        .rx_valid   (f_rx_valid),
        .rx_data    (f_rx_data),
        .rx_idx     (f_rx_idx),
        .fdone      (f_done)
    );

    prx_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .max_len    (max_len),
        .eop        (eop),
        .tmo        (tmo),
        .f_done     (f_done),
        .f_rx_valid (f_rx_valid),
        .f_rx_data  (f_rx_data),
        .f_rx_idx   (f_rx_idx),
        .wait_en    (wait_en),
        .f_go       (f_go),
        .f_hdr      (f_hdr),
        .f_cnt      (f_cnt),
        .pay_valid  (pay_valid),
        .pay_data   (pay_data),
        .done       (done),
        .result     (result)
    );

    assign res_ok   = result.ok;
    assign res_len  = result.len;
    assign res_rssi = result.rssi;
    assign res_lqi  = result.lqi;

endmodule

// File: rtl/prx_rx_checker.sv
module prx_rx_checker (
    input logic       clk,
    input logic       rst,
    input logic       xfer_req,
    input logic       xfer_ack,
    input logic [7:0] xfer_tx,
    input logic       xfer_first,
    input logic       xfer_last,
    input logic       pay_valid,
    input logic       done
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx) && $stable(xfer_first) && $stable(xfer_last))); // R11

    AST_FRAME_OPENS: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_req) |-> xfer_first); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_DONE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> !xfer_req); // R9

    AST_PAY_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        pay_valid |-> $past(xfer_ack)); // R6

endmodule

bind prx_rx_sequencer prx_rx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .xfer_req   (xfer_req),
    .xfer_ack   (xfer_ack),
    .xfer_tx    (xfer_tx),
    .xfer_first (xfer_first),
    .xfer_last  (xfer_last),
    .pay_valid  (pay_valid),
    .done       (done)
);

// File: tb/prx_rx_sequencer_tb.sv
module prx_rx_sequencer_tb;

    localparam int TO = 300;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] max_len = '0;
    logic       pkt_pin = 1'b0;
    logic       xfer_req, xfer_first, xfer_last;
    logic [7:0] xfer_tx;
    logic       xfer_ack = 1'b0;
    logic [7:0] xfer_rx = '0;
    logic       pay_valid, done, res_ok;
    logic [7:0] pay_data, res_len, res_rssi;
    logic [6:0] res_lqi;

    always #5 clk = ~clk;

    prx_rx_sequencer #(.TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst(rst), .start(start), .max_len(max_len), .pkt_pin(pkt_pin),
        .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_first(xfer_first),
        .xfer_last(xfer_last), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
        .pay_valid(pay_valid), .pay_data(pay_data), .done(done),
        .res_ok(res_ok), .res_len(res_len), .res_rssi(res_rssi), .res_lqi(res_lqi)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // radio model state
    logic [7:0] m_cnt, m_len, m_st2, m_rssi, m_pbase;
    logic [7:0] hdr_log [16];
    int         dlen_log [16];
    int         nfr, cur, burst_n, npay, nz_tx;
    logic [7:0] cur_hdr;
    logic [7:0] pay_buf [32];
    bit         done_seen;

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rx();
        if (xfer_first) return 8'h0F;
        case (cur_hdr)
            8'hFB: return m_cnt;
            8'hBF: return m_len;
            8'hFF: begin
                if (burst_n == 1) return m_pbase + 8'(cur);
                return (cur == 0) ? m_rssi : m_st2;
            end
            default: return 8'h00;
        endcase
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (pay_valid && npay < 32) begin pay_buf[npay] = pay_data; npay++; end
        if (done) done_seen = 1'b1;
        if (rst) xfer_ack = 1'b0;
        else if (xfer_ack) xfer_ack = 1'b0;
        else if (xfer_req) begin
            xfer_rx = model_rx();
            if (xfer_first) begin
                cur_hdr = xfer_tx;
                cur = 0;
                if (xfer_tx == 8'hFF) burst_n++;
                if (nfr < 16) hdr_log[nfr] = xfer_tx;
            end else begin
                if (xfer_tx != 8'h00) nz_tx++;
                cur++;
            end
            if (xfer_last) begin
                if (nfr < 16) dlen_log[nfr] = cur;
                nfr++;
            end
            xfer_ack = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic clear_log();
        nfr = 0; cur = 0; burst_n = 0; npay = 0; nz_tx = 0; done_seen = 1'b0; cur_hdr = 8'h00;
    endtask

    task automatic wait_done(input int limit, output int n);
        n = 0;
        while (!done_seen && n < limit) begin
            @(negedge clk); #1;
            n++;
        end
        chk(done_seen, "R9 done reached", n, limit);
    endtask

    task automatic pulse_start(input logic [7:0] mx);
        @(negedge clk);
        start = 1'b1; max_len = mx;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_frames(input string tag, input int n, input logic [47:0] hx, input logic [47:0] dx);
        chk(nfr == n, {tag, " frame count"}, nfr, n);
        for (int i = 0; i < n && i < nfr; i++) begin
            chk(hdr_log[i] == hx[47-8*i -: 8], {tag, " header"}, hdr_log[i], hx[47-8*i -: 8]);
            chk(dlen_log[i] == int'(dx[47-8*i -: 8]), {tag, " data bytes"}, dlen_log[i], dx[47-8*i -: 8]);
        end
        chk(nz_tx == 0, "R11 data bytes sent as zero", nz_tx, 0);
    endtask

    task automatic check_payload(input string tag, input int n);
        chk(npay == n, {tag, " payload count"}, npay, n);
        for (int i = 0; i < n && i < npay; i++)
            chk(pay_buf[i] == m_pbase + 8'(i), {tag, " payload byte"}, pay_buf[i], m_pbase + 8'(i));
    endtask

    // one receive attempt that reaches the FIFO
    task automatic run_pkt(input string tag, input logic [7:0] cnt, input logic [7:0] plen,
                           input logic [7:0] mx, input logic [7:0] st2, input logic [7:0] rs,
                           input int hold, input bit dbl);
        int n;
        m_cnt = cnt; m_len = plen; m_st2 = st2; m_rssi = rs; m_pbase = 8'h40 + plen;
        clear_log();
        if (hold > 0) pkt_pin = 1'b1;
        pulse_start(mx);
        if (dbl) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            chk(nfr == 1, "R3 no frame while pin high", nfr, 1);
            pkt_pin = 1'b0;
        end
        wait_done(4000, n);
        @(negedge clk); #1;
        chk(done == 1'b0, "R7 done lasts one cycle", done, 0);
    endtask

    task automatic t_accept(input string tag, input logic [7:0] plen, input logic [7:0] mx,
                            input logic [7:0] st2, input int hold, input bit dbl);
        run_pkt(tag, 8'h20, plen, mx, st2, 8'hC3, hold, dbl);
        check_frames({tag, " R6 R9"}, 6, 48'h34FBBFFFFF3A, {8'd0, 8'd1, 8'd1, plen, 8'd2, 8'd0});
        check_payload({tag, " R6"}, int'(plen));
        chk(res_ok == st2[7], {tag, " R7 ok flag"}, res_ok, st2[7]);
        chk(res_lqi == st2[6:0], {tag, " R7 lqi"}, res_lqi, st2[6:0]);
        chk(res_rssi == 8'hC3, {tag, " R7 rssi"}, res_rssi, 8'hC3);
        chk(res_len == plen, {tag, " R5 length"}, res_len, plen);
    endtask

    task automatic t_over();
        run_pkt("over", 8'h30, 8'd9, 8'd8, 8'h80, 8'h11, 0, 1'b0);
        check_frames("R8 over-length R9", 4, 48'h34FBBF3A0000, 48'h000101000000);
        chk(npay == 0, "R8 no payload", npay, 0);
        chk(res_ok == 1'b0, "R8 fail flag", res_ok, 0);
        chk(res_len == 8'd9, "R8 length reported", res_len, 9);
    endtask

    task automatic t_empty();
        run_pkt("empty", 8'h80, 8'd3, 8'd8, 8'h80, 8'h11, 0, 1'b0);
        check_frames("R4 empty FIFO", 2, 48'h34FB00000000, 48'h000100000000);
        chk(res_ok == 1'b0, "R4 fail flag", res_ok, 0);
        chk(res_len == 8'd0, "R4 length zero", res_len, 0);
    endtask

    task automatic t_timeout();
        int n;
        clear_log();
        pkt_pin = 1'b1;
        pulse_start(8'd8);
        wait_done(4000, n);
        pkt_pin = 1'b0;
        check_frames("R10 timeout", 3, 48'h34363A000000, 48'h0);
        chk(n >= TO, "R10 wait length", n, TO);
        chk(res_ok == 1'b0, "R10 fail flag", res_ok, 0);
        chk(res_len == 8'd0, "R10 length zero", res_len, 0);
    endtask

    task automatic t_collide();
        int n;
        logic [7:0] len_before;
        m_cnt = 8'h10; m_len = 8'd2; m_st2 = 8'h85; m_rssi = 8'h22; m_pbase = 8'h50;
        clear_log();
        pulse_start(8'd4);
        wait_done(4000, n);
        len_before = res_len;
        start = 1'b1; max_len = 8'd4;   // lands in the done cycle
        @(negedge clk);
        start = 1'b0;
        nfr = 0;
        repeat (40) @(negedge clk);
        #1;
        chk(nfr == 0 && xfer_req == 1'b0, "R2 start in done cycle ignored", nfr, 0);
        chk(res_len == len_before, "R2 results held", res_len, len_before);
    endtask

    initial begin
        clear_log();
        repeat (4) @(negedge clk);
        #1;
        chk(xfer_req == 1'b0, "R1 no request in reset", xfer_req, 0);
        chk(done == 1'b0 && pay_valid == 1'b0, "R1 quiet outputs in reset", done, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        chk(xfer_req == 1'b0 && nfr == 0, "R1 idle after reset", nfr, 0);

        t_accept("good R2", 8'd5, 8'd8, 8'hAA, 0, 1'b1);
        t_accept("crc bad", 8'd4, 8'd8, 8'h15, 0, 1'b0);
        t_accept("len equals max", 8'd8, 8'd8, 8'h81, 0, 1'b0);
        t_accept("len zero", 8'd0, 8'd4, 8'h83, 0, 1'b0);
        t_accept("pin held R3", 8'd3, 8'd8, 8'h9C, 150, 1'b0);
        t_over();
        t_empty();
        t_timeout();
        t_collide();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule